// File: doc/BRIEF.md
# Shift-Register Raster Timing Generator

This block produces the horizontal sync, vertical sync and display-enable signals of a raster display, together with one-cycle strobes that mark the first clock of every line and of every frame. The horizontal and vertical positions are not kept in binary counters. Each position is held in a 16-bit maximal-length linear feedback shift register, so the next-state logic of a position is one XOR gate deep, whatever the line or frame size.

Every timing point the block uses (line end, frame end, sync edges and display window edges) arrives already encoded. An encoded value is the register state reached after the plain count has been stepped from the all-ones start state, and an equality comparator detects it. A register decoder upstream converts plain mode timings into these encoded values once per mode change and holds them steady while the block runs. The enable input acts as the blank control: while it is low, the outputs are held low and both positions are reloaded to count zero.

Top module: `lfsr_vtg`

## Requirements
- R1: While `rst_n` or `enable` is low at a clock edge, both positions reload to count 0 (state 16'hFFFF). While `enable` is low, `hsync`, `vsync`, `de`, `sol` and `sof` are all 0.
- R2: One step moves the position register left by one bit and discards bit 15. The new bit 0 is the XOR of the old bits 15, 4, 2 and 1. The encoded form of count n is 16'hFFFF stepped n times.
- R3: With `x_end` set to the encoding of N-1, the horizontal count runs 0..N-1 and then returns to 0, so a line lasts N clocks.
- R4: With `y_end` set to the encoding of L, the line count runs 0..L-1 and then returns to 0, so a frame lasts L lines. The line count moves only on the clock that ends a line.
- R5: With `hs_start` set to the encoding of 1 and `hs_end` set to the encoding of W+1, `hsync` is high for horizontal counts 1..W, which is W clocks after one clock of count 0.
- R6: With `vs_start` set to the encoding of 0 and `vs_end` set to the encoding of W, `vsync` is high for line counts 0..W-1.
- R7: `de` is high exactly when the horizontal count lies in [xs, xe) and the line count lies in [ys, ye). Here `x_de_start`, `x_de_end`, `y_de_start` and `y_de_end` carry the encodings of xs, xe, ys and ye.
- R8: `sol` is high on horizontal count 0. `sof` is high on horizontal count 0 of line 0 only.
- R9: When a window's start and stop encodings are equal, the window is empty and its output stays low. A stop match takes priority over a start match.
- R10: After `enable` drops in the middle of a frame and then returns, output resumes from count 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Blank control: 1 runs the raster, 0 blanks and restarts |
| x_de_start | input | 16 | Encoded horizontal count where display-enable opens |
| x_de_end | input | 16 | Encoded horizontal count where display-enable closes |
| y_de_start | input | 16 | Encoded line count where display-enable opens |
| y_de_end | input | 16 | Encoded line count where display-enable closes |
| x_end | input | 16 | Encoded last horizontal count of a line (total - 1) |
| hs_start | input | 16 | Encoded horizontal count where hsync rises |
| hs_end | input | 16 | Encoded horizontal count where hsync falls |
| y_end | input | 16 | Encoded line total of a frame |
| vs_start | input | 16 | Encoded line count where vsync rises |
| vs_end | input | 16 | Encoded line count where vsync falls |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Display enable |
| sol | output | 1 | Start-of-line strobe |
| sof | output | 1 | Start-of-frame strobe |

## Verification
All five outputs are decoded from registers, with no further pipeline stage. A clock's outputs therefore belong to the position held after the previous rising edge, and a change on `enable` shows on the outputs in the same cycle. The driver applies every input on the falling edge and at that moment pushes the outputs an integer raster model predicts. The monitor compares them one time unit later, so each expected item lines up with exactly one design cycle. Pulse positions and widths follow from this cycle-by-cycle comparison, across two line and frame geometries, empty windows, and a blank in the middle of a frame.

// File: rtl/lfsr_vtg_pkg.sv
// Package: shared position type, start state, tap mask and step function
// for the shift-register raster timing generator.
// Assumes a 16-bit maximal-length register with taps on bits 15, 4, 2, 1.
package lfsr_vtg_pkg;

    localparam int POS_W = 16;

    typedef logic [POS_W-1:0] pos_t;

    // State that stands for count zero.
    localparam pos_t POS_SEED = {POS_W{1'b1}};

    // Feedback taps: bits 15, 4, 2 and 1.
    localparam pos_t TAP_MASK = pos_t'(16'h8016);

    // One advance of the position register.
    function automatic pos_t pos_step(input pos_t p);
        return {p[POS_W-2:0], ^(p & TAP_MASK)};
    endfunction

endpackage

// File: rtl/lfsr_axis.sv
// Module: one position axis held in a shift register.
// It advances when adv is high. It returns to the start state either when
// the current value equals end_val (WRAP_ON_NEXT = 0) or when the stepped
// value would equal end_val (WRAP_ON_NEXT = 1).
// nxt gives the value pos takes at the coming edge.
// Assumes end_val is steady while the axis runs.
module lfsr_axis
    import lfsr_vtg_pkg::*;
#(
    parameter bit WRAP_ON_NEXT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic adv,
    input  pos_t end_val,
    output pos_t pos,
    output pos_t nxt,
    output logic wrap
);

    pos_t stepped;
    logic hit;

    assign stepped = pos_step(pos);

    // Wrap detection, chosen by parameter.
    generate
        if (WRAP_ON_NEXT) begin : g_next
            assign hit = (stepped == end_val);
        end else begin : g_cur
            assign hit = (pos == end_val);
        end
    endgenerate

    assign wrap = adv && hit;

    // Next-state selection for the position.
    always_comb begin
        if (restart)      nxt = POS_SEED;
        else if (wrap)    nxt = POS_SEED;
        else if (adv)     nxt = stepped;
        else              nxt = pos;
    end

    // Position register.
    always_ff @(posedge clk) begin
        if (!rst_n) pos <= POS_SEED;
        else        pos <= nxt;
    end

    // R2: a shift register started from all ones never locks into zero.
    a_r2_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pos != '0);

    // R2: an advance without a wrap moves exactly one step.
    a_r2_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && adv && !hit) |=> (pos == pos_step($past(pos))));

endmodule

// File: rtl/lfsr_window.sv
// Module: set/clear flag that marks when an axis position lies inside
// [start, stop). The flag is re-evaluated on every edge where the axis
// updates, from the position it is about to take.
// Priority: a stop match, then a start match, then count zero (clear),
// then hold. A restart evaluates count zero with a cleared hold.
// Assumes start and stop are steady while the axis runs.
module lfsr_window
    import lfsr_vtg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic upd,
    input  pos_t nxt_pos,
    input  pos_t start,
    input  pos_t stop,
    output logic flag
);

    // Flag value for a given coming position and held value.
    function automatic logic judge(input pos_t p, input pos_t s,
                                   input pos_t e, input logic hold);
        if (p == e)             return 1'b0;
        else if (p == s)        return 1'b1;
        else if (p == POS_SEED) return 1'b0;
        else                    return hold;
    endfunction

    // Window flag register.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) flag <= judge(POS_SEED, start, stop, 1'b0);
        else if (upd)          flag <= judge(nxt_pos, start, stop, flag);
    end

    // R9: when start equals stop the window stays empty.
    a_r9_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
        (start == stop && $stable(start)) |=> !flag);

endmodule

// File: rtl/lfsr_vtg.sv
// Module: raster timing generator built on shift-register positions.
// A horizontal axis advances on every enabled clock. A vertical axis
// advances on each line wrap. Four window flags give the horizontal
// display span, hsync, the vertical display span and vsync. The outputs
// are gated by enable. Lowering enable restarts both axes at count zero.
// Assumes every timing input is already encoded, and steady while enabled.
module lfsr_vtg
    import lfsr_vtg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic [15:0] x_de_start,
    input  logic [15:0] x_de_end,
    input  logic [15:0] y_de_start,
    input  logic [15:0] y_de_end,
    input  logic [15:0] x_end,
    input  logic [15:0] hs_start,
    input  logic [15:0] hs_end,
    input  logic [15:0] y_end,
    input  logic [15:0] vs_start,
    input  logic [15:0] vs_end,
    output logic        hsync,
    output logic        vsync,
    output logic        de,
    output logic        sol,
    output logic        sof
);

    localparam int NWIN   = 4;
    localparam int W_HDE  = 0;
    localparam int W_HS   = 1;
    localparam int W_VDE  = 2;
    localparam int W_VS   = 3;

    logic restart;
    pos_t h_pos, h_nxt, v_pos, v_nxt;
    logic h_wrap, v_wrap;

    pos_t         win_start [NWIN];
    pos_t         win_stop  [NWIN];
    pos_t         win_nxt   [NWIN];
    logic [NWIN-1:0] win_upd;
    logic [NWIN-1:0] win_flag;

    assign restart = !enable;

    // Horizontal axis: wraps after the clock whose count equals x_end.
    lfsr_axis #(.WRAP_ON_NEXT(1'b0)) u_h_axis (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .adv     (1'b1),
        .end_val (x_end),
        .pos     (h_pos),
        .nxt     (h_nxt),
        .wrap    (h_wrap)
    );

    // Vertical axis: steps on a line wrap, wraps when the step reaches y_end.
    lfsr_axis #(.WRAP_ON_NEXT(1'b1)) u_v_axis (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .adv     (h_wrap),
        .end_val (y_end),
        .pos     (v_pos),
        .nxt     (v_nxt),
        .wrap    (v_wrap)
    );

    // Route the axis and the bounds of each window.
    always_comb begin
        win_start[W_HDE] = x_de_start; win_stop[W_HDE] = x_de_end;
        win_start[W_HS]  = hs_start;   win_stop[W_HS]  = hs_end;
        win_start[W_VDE] = y_de_start; win_stop[W_VDE] = y_de_end;
        win_start[W_VS]  = vs_start;   win_stop[W_VS]  = vs_end;
        win_nxt[W_HDE] = h_nxt; win_nxt[W_HS] = h_nxt;
        win_nxt[W_VDE] = v_nxt; win_nxt[W_VS] = v_nxt;
        win_upd[W_HDE] = 1'b1;  win_upd[W_HS] = 1'b1;
        win_upd[W_VDE] = h_wrap; win_upd[W_VS] = h_wrap;
    end

    // One flag per window.
    generate
        for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
            lfsr_window u_win (
                .clk     (clk),
                .rst_n   (rst_n),
                .restart (restart),
                .upd     (win_upd[gi]),
                .nxt_pos (win_nxt[gi]),
                .start   (win_start[gi]),
                .stop    (win_stop[gi]),
                .flag    (win_flag[gi])
            );
        end
    endgenerate

    // Output decode, blanked while enable is low.
    always_comb begin
        hsync = enable && win_flag[W_HS];
        vsync = enable && win_flag[W_VS];
        de    = enable && win_flag[W_HDE] && win_flag[W_VDE];
        sol   = enable && (h_pos == POS_SEED);
        sof   = enable && (h_pos == POS_SEED) && (v_pos == POS_SEED);
    end

    // R1: a disabled clock restarts both axes.
    a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (h_pos == POS_SEED && v_pos == POS_SEED));

    // R1: nothing is driven while blanked.
    a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !(hsync || vsync || de || sol || sof));

    // R3: the line ends after the x_end count.
    a_r3_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && h_pos == x_end) |=> (h_pos == POS_SEED));

    // R4: the line count holds except at a line wrap.
    a_r4_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && h_pos != x_end) |=> $stable(v_pos));

    // R8: a frame strobe is always also a line strobe.
    a_r8_sof_in_sol: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> sol);

    // R4: a frame wrap lands on line zero.
    a_r4_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && v_wrap) |=> (v_pos == POS_SEED));

endmodule

// File: tb/lfsr_vtg_tb.sv
// Scoreboard bench: the driver applies inputs on the falling edge and
// pushes the outputs an integer raster model predicts. The monitor pops
// and compares one time unit later.
module lfsr_vtg_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [15:0] x_de_start, x_de_end, y_de_start, y_de_end;
    logic [15:0] x_end, hs_start, hs_end, y_end, vs_start, vs_end;
    logic hsync, vsync, de, sol, sof;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    typedef struct {
        logic [4:0] exp;   // {hsync, vsync, de, sol, sof}
        string      phase;
    } item_t;

    item_t exp_q[$];

    // Model state.
    int m_n, m_l, m_hsw, m_vsw, m_xs, m_xe, m_ys, m_ye;
    int hc = 0, vc = 0;

    always #5 clk = ~clk;

    lfsr_vtg u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .x_de_start(x_de_start), .x_de_end(x_de_end),
        .y_de_start(y_de_start), .y_de_end(y_de_end),
        .x_end(x_end), .hs_start(hs_start), .hs_end(hs_end),
        .y_end(y_end), .vs_start(vs_start), .vs_end(vs_end),
        .hsync(hsync), .vsync(vsync), .de(de), .sol(sol), .sof(sof)
    );

    // R2: encoding of a plain count, from the stepping rule.
    function automatic logic [15:0] enc(input int n);
        logic [15:0] lv = 16'hFFFF;
        for (int i = 0; i < n; i++)
            lv = {lv[14:0], lv[15] ^ lv[4] ^ lv[2] ^ lv[1]};
        return lv;
    endfunction

    function automatic logic [4:0] predict(input logic en);
        logic [4:0] r;
        if (!en) return 5'b0;
        r[4] = (hc >= 1) && (hc < m_hsw + 1);                       // R5
        r[3] = (vc < m_vsw);                                        // R6
        r[2] = (hc >= m_xs) && (hc < m_xe) && (vc >= m_ys) && (vc < m_ye); // R7
        r[1] = (hc == 0);                                           // R8
        r[0] = (hc == 0) && (vc == 0);                              // R8
        return r;
    endfunction

    // One cycle: apply inputs, push the expectation, advance the model.
    task automatic step_cycle(input logic en, input logic rst, input string ph);
        item_t it;
        @(negedge clk);
        enable = en;
        rst_n  = rst;
        it.exp   = predict(en);
        it.phase = ph;
        exp_q.push_back(it);
        if (!en || !rst) begin
            hc = 0; vc = 0;
        end else if (hc == m_n - 1) begin
            hc = 0;
            vc = (vc + 1 == m_l) ? 0 : vc + 1;
        end else begin
            hc = hc + 1;
        end
    endtask

    task automatic run(input int n, input logic en, input string ph);
        for (int i = 0; i < n; i++) step_cycle(en, 1'b1, ph);
    endtask

    // Load a mode while blanked; the geometry follows R3..R7.
    task automatic set_cfg(input int n, input int l, input int hsw, input int vsw,
                           input int xs, input int xe, input int ys, input int ye);
        @(negedge clk);
        enable = 1'b0;
        m_n = n; m_l = l; m_hsw = hsw; m_vsw = vsw;
        m_xs = xs; m_xe = xe; m_ys = ys; m_ye = ye;
        x_end = enc(n - 1);  y_end = enc(l);                         // R3 R4
        hs_start = enc(1);   hs_end = enc(hsw + 1);                  // R5
        vs_start = enc(0);   vs_end = enc(vsw);                      // R6
        x_de_start = enc(xs); x_de_end = enc(xe);                    // R7
        y_de_start = enc(ys); y_de_end = enc(ye);
        run(2, 1'b0, "R1 blank");
    endtask

    // Monitor: pop and compare each field.
    initial begin
        string names [5];
        string reqs  [5];
        logic [4:0] got;
        item_t it;
        names = '{"sof", "sol", "de", "vsync", "hsync"};
        reqs  = '{"R4 R8", "R2 R3 R8", "R7 R9", "R6", "R5"};
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                it  = exp_q.pop_front();
                got = {hsync, vsync, de, sol, sof};
                for (int b = 0; b < 5; b++) begin
                    checks++;
                    if (got[b] !== it.exp[b]) begin
                        fails++;
                        $display("FAIL %s [%s] %s: got %b expected %b",
                                 reqs[b], it.phase, names[b], got[b], it.exp[b]);
                    end
                end
            end
        end
    end

    // Stimulus.
    initial begin
        x_de_start = 0; x_de_end = 0; y_de_start = 0; y_de_end = 0;
        x_end = 0; hs_start = 0; hs_end = 0; y_end = 0; vs_start = 0; vs_end = 0;
        m_n = 1; m_l = 1; m_hsw = 0; m_vsw = 0; m_xs = 0; m_xe = 0; m_ys = 0; m_ye = 0;
        // R1: reset state with blank.
        for (int i = 0; i < 4; i++) step_cycle(1'b0, 1'b0, "R1 reset");
        // Geometry A.
        set_cfg(20, 12, 3, 2, 6, 18, 3, 11);
        run(3 * 20 * 12, 1'b1, "geometry A");
        // R10: blank in mid-frame, then resume.
        run(20 * 5 + 7, 1'b1, "R10 pre");
        run(3, 1'b0, "R1 R10 blank");
        run(20 * 12 + 25, 1'b1, "R10 resume");
        // Geometry B.
        set_cfg(33, 9, 5, 1, 8, 30, 2, 8);
        run(3 * 33 * 9, 1'b1, "geometry B");
        // R9: empty display windows on both axes.
        set_cfg(16, 10, 2, 3, 5, 5, 4, 4);
        run(2 * 16 * 10, 1'b1, "R9 empty");
        // R9: horizontal empty only, vertical normal.
        set_cfg(16, 10, 4, 2, 7, 7, 1, 9);
        run(16 * 10, 1'b1, "R9 h empty");
        run(2, 1'b0, "R1 end");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        #(200000 * 10);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule